// File: doc/BRIEF.md
# PLL Loss-of-Lock Detector

This block turns a stream of cycle-slip pulses from a PLL phase comparator into a single active-high loss-of-lock flag, `lol`. An interval timer measures how long the loop has gone without a slip. The flag clears only once that slip-free run is longer than a retrigger window. The window is chosen by a 3-bit loop-bandwidth code, and each step up in bandwidth roughly halves it. Window lengths are held as system-clock tick counts, computed at elaboration from the clock-frequency parameter and rounded to the nearest tick.

Some conditions force the flag high: the block's own reset, an external reset request, the wait for a valid input clock that follows a reset, any cycle in which calibration is busy, and a change of the bandwidth code. Each of these also restarts the interval measurement. Every assertion of the flag lasts at least a programmable minimum width, which defaults to one millisecond of clock ticks. The output is a register.

Top module: `lol_detector`

## Requirements
- R1: While `rst` is high, and after a reset or a `rst_req` pulse until `clk_valid` has been sampled high, `lol` is 1. With no later slip, calibration or code change, `lol` falls limit+1 cycles after the first edge that samples `clk_valid` high.
- R2: `lol` is 1 in the cycle after any cycle in which `cal_busy` is high. Once `cal_busy` drops, `lol` falls limit+1 cycles after the last edge that sampled it high, provided the minimum width has already elapsed.
- R3: A slip pulse sampled at edge E sets `lol` to 1 from E onward. If no further slip arrives, `lol` falls at edge E + max(limit+1, MIN_LOL_TICKS) when `lol` was low before E.
- R4: The limit in ticks is round(t × CLK_HZ), where t is the retrigger time selected by `bw_code`. The codes select 53, 26.5, 13.3, 6.6, 3.3, 1.66 and 0.833 ms for codes 0 to 6, lowest bandwidth first. Code 7 selects the same time as code 6.
- R5: A slip that arrives in the first cycle the timer has reached the limit counts as a slip. `lol` stays 1, and the measurement restarts from that slip.
- R6: Each high pulse of `lol` lasts at least MIN_LOL_TICKS cycles, even when lock conditions return sooner.
- R7: A change of `bw_code` between consecutive cycles sets `lol` to 1 in the next cycle and restarts the measurement under the new limit, with the same fall timing as R3.
- R8: The interval timer saturates at its all-ones count rather than wrapping. A slip-free run of any length longer than the limit keeps `lol` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | External reset request, one or more cycles |
| clk_valid | input | 1 | Input reference clock is present |
| cal_busy | input | 1 | Internal PLL calibration in progress |
| slip | input | 1 | Single-cycle phase cycle-slip pulse |
| bw_code | input | 3 | Loop bandwidth range code, 0 = lowest |
| lol | output | 1 | Loss of lock, active high, registered |

## Verification
The bench sweeps all eight bandwidth codes and checks the exact edge at which `lol` falls, both after the code change and after a slip. An off-by-one compare or a wrong rounding of any table entry would move that edge by one or more cycles. On codes 6 and 7 the window is shorter than the minimum width, so a missing pulse stretcher would let the flag fall early. It also places a slip exactly on the expiry cycle, where a timer that treated the expiry as lock would drop `lol` in that cycle. Finally, it idles past the timer's full count, where a wrapping counter would raise a spurious loss-of-lock pulse.

// File: rtl/lol_pkg.sv
package lol_pkg;

  typedef enum logic [0:0] {
    ST_WAIT_CLK = 1'b0,
    ST_RUN      = 1'b1
  } seq_state_t;

  // Retrigger window in microseconds per bandwidth code (code 7 aliases code 6).
  function automatic longint unsigned retrig_us(input logic [2:0] code);
    case (code)
      3'd0:    return 64'd53000;
      3'd1:    return 64'd26500;
      3'd2:    return 64'd13300;
      3'd3:    return 64'd6600;
      3'd4:    return 64'd3300;
      3'd5:    return 64'd1660;
      default: return 64'd833;
    endcase
  endfunction

  // Microseconds to clock ticks, rounded to nearest.
  function automatic longint unsigned us_to_ticks(input longint unsigned us,
                                                  input longint unsigned hz);
    return (us * hz + 64'd500000) / 64'd1000000;
  endfunction

endpackage

// File: rtl/lol_retrig_lut.sv
module lol_retrig_lut #(
  parameter longint unsigned CLK_HZ = 200_000_000,
  parameter int              CNT_W  = 24
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] limit
);
  localparam int NCODES = 8;

  logic [CNT_W-1:0] tbl [NCODES];

  for (genvar i = 0; i < NCODES; i++) begin : g_tbl
    localparam longint unsigned TK =
      lol_pkg::us_to_ticks(lol_pkg::retrig_us(3'(i)), CLK_HZ);
    assign tbl[i] = CNT_W'(TK);
  end

  assign limit = tbl[code];
endmodule

// File: rtl/lol_interval_timer.sv
module lol_interval_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/lol_stretch.sv
module lol_stretch #(
  parameter int unsigned MIN_TICKS = 200_000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lol
);
  localparam int HOLD_W = $clog2(MIN_TICKS + 1);
  localparam logic [HOLD_W-1:0] MIN_V = HOLD_W'(MIN_TICKS);

  logic [HOLD_W-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lol  <= 1'b1;
      hcnt <= HOLD_W'(1);
    end else if (!lol) begin
      if (raw) begin
        lol  <= 1'b1;
        hcnt <= HOLD_W'(1);
      end
    end else begin
      if (hcnt < MIN_V) hcnt <= hcnt + 1'b1;
      if (!raw && hcnt >= MIN_V) lol <= 1'b0;
    end
  end
endmodule

// File: rtl/lol_detector.sv
module lol_detector #(
  parameter longint unsigned CLK_HZ        = 200_000_000,
  parameter int unsigned     MIN_LOL_TICKS = int'(CLK_HZ / 1000)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_req,
  input  logic       clk_valid,
  input  logic       cal_busy,
  input  logic       slip,
  input  logic [2:0] bw_code,
  output logic       lol
);
  import lol_pkg::*;

  localparam longint unsigned MAX_TICKS = us_to_ticks(64'd53000, CLK_HZ);
  localparam int CNT_W = $clog2(MAX_TICKS + 2);

  seq_state_t       state;
  logic [2:0]       bw_q;
  logic             bw_chg;
  logic             force_lol;
  logic             expired;
  logic             raw_lol;
  logic [CNT_W-1:0] limit;

  // Reset sequencing: hold until a valid reference clock appears.
  always_ff @(posedge clk) begin
    if (rst || rst_req) begin
      state <= ST_WAIT_CLK;
    end else if (state == ST_WAIT_CLK && clk_valid) begin
      state <= ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    bw_q <= bw_code;
  end

  assign bw_chg    = (bw_code != bw_q);
  assign force_lol = (state != ST_RUN) || cal_busy || bw_chg || rst_req;
  assign raw_lol   = force_lol || slip || !expired;

  lol_retrig_lut #(
    .CLK_HZ (CLK_HZ),
    .CNT_W  (CNT_W)
  ) u_lut (
    .code  (bw_q),
    .limit (limit)
  );

  lol_interval_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (force_lol || slip),
    .limit   (limit),
    .expired (expired)
  );

  lol_stretch #(
    .MIN_TICKS (MIN_LOL_TICKS)
  ) u_stretch (
    .clk (clk),
    .rst (rst),
    .raw (raw_lol),
    .lol (lol)
  );
endmodule

// File: rtl/lol_checker.sv
module lol_checker #(
  parameter int unsigned MIN_TICKS = 200_000
) (
  input logic       clk,
  input logic       rst,
  input logic       rst_req,
  input logic       cal_busy,
  input logic       slip,
  input logic [2:0] bw_code,
  input logic       lol
);
  localparam int W = $clog2(MIN_TICKS + 1);
  localparam logic [W-1:0] MIN_V = W'(MIN_TICKS);

  logic [W-1:0] width;

  always_ff @(posedge clk) begin
    if (rst || !lol) width <= '0;
    else if (width < MIN_V) width <= width + 1'b1;
  end

  assert_rst_req_forces_R1: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> lol);

  assert_cal_forces_R2: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> lol);

  assert_slip_sets_R3: assert property (@(posedge clk) disable iff (rst)
    slip |=> lol);

  assert_min_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(lol) |-> (width >= MIN_V));

  assert_code_change_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(bw_code) |=> lol);
endmodule

bind lol_detector lol_checker #(
  .MIN_TICKS (MIN_LOL_TICKS)
) u_lol_checker (
  .clk      (clk),
  .rst      (rst),
  .rst_req  (rst_req),
  .cal_busy (cal_busy),
  .slip     (slip),
  .bw_code  (bw_code),
  .lol      (lol)
);

// File: tb/lol_detector_bench.sv
`timescale 1ns/1ps
module lol_detector_bench;
  localparam longint unsigned CLK_HZ = 100_000;
  localparam int MIN_T = 120;

  logic clk = 1'b0;
  logic rst = 1'b1, rst_req = 1'b0, clk_valid = 1'b0, cal_busy = 1'b0, slip = 1'b0;
  logic [2:0] bw_code = 3'd6;
  logic lol;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lol_detector #(
    .CLK_HZ        (CLK_HZ),
    .MIN_LOL_TICKS (MIN_T)
  ) u_lol_detector (
    .clk (clk), .rst (rst), .rst_req (rst_req), .clk_valid (clk_valid),
    .cal_busy (cal_busy), .slip (slip), .bw_code (bw_code), .lol (lol)
  );

  function automatic int exp_limit(input int c);
    longint unsigned us;
    case (c)
      0: us = 53000; 1: us = 26500; 2: us = 13300; 3: us = 6600;
      4: us = 3300;  5: us = 1660;  default: us = 833;
    endcase
    return int'((us * CLK_HZ + 500000) / 1000000);
  endfunction

  function automatic int fall_after(input int c);
    return (exp_limit(c) + 1 > MIN_T) ? exp_limit(c) + 1 : MIN_T;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: lol=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Check lol is 1 at E+f-1 and 0 at E+f, starting at the negedge after E.
  task automatic check_fall(input int f, input string tag);
    wait_n(f - 1);
    chk(lol, 1'b1, {tag, " before fall"});
    wait_n(1);
    chk(lol, 1'b0, {tag, " at fall"});
  endtask

  task automatic pulse_slip;
    @(negedge clk) slip = 1'b1;
    @(negedge clk) slip = 1'b0;
  endtask

  task automatic set_code(input int c);
    @(negedge clk) bw_code = 3'(c);
    @(negedge clk);
    chk(lol, 1'b1, $sformatf("R7 code change to %0d", c));
    check_fall(fall_after(c), $sformatf("R4 window code %0d", c));
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic bad_seen;
    wait_n(3);
    chk(lol, 1'b1, "R1 during reset");
    @(negedge clk) rst = 1'b0;
    wait_n(500);
    chk(lol, 1'b1, "R1 waiting for clk_valid");
    @(negedge clk) clk_valid = 1'b1;
    @(negedge clk);
    check_fall(exp_limit(6) + 1, "R1 release after clk_valid");

    // Sweep all codes: window after code change, then after a slip.
    for (int c = 0; c < 8; c++) begin
      set_code(c);
      pulse_slip();
      chk(lol, 1'b1, $sformatf("R3 slip raises lol code %0d", c));
      check_fall(fall_after(c),
                 $sformatf("R3 R6 slip-free fall code %0d", c));
    end

    // Slip exactly on the expiry cycle (code 5, window longer than minimum).
    set_code(5);
    pulse_slip();
    wait_n(exp_limit(5));
    chk(lol, 1'b1, "R5 before expiry slip");
    slip = 1'b1;
    @(negedge clk) slip = 1'b0;
    chk(lol, 1'b1, "R5 slip at expiry keeps lol");
    check_fall(exp_limit(5) + 1, "R5 restart from expiry slip");

    // Calibration forces lol and restarts the measurement.
    set_code(7);
    @(negedge clk) cal_busy = 1'b1;
    wait_n(200);
    chk(lol, 1'b1, "R2 during calibration");
    cal_busy = 1'b0;
    wait_n(exp_limit(7));
    chk(lol, 1'b1, "R2 before fall after calibration");
    wait_n(1);
    chk(lol, 1'b0, "R2 fall after calibration");

    // External reset request waits for clk_valid again.
    @(negedge clk) begin rst_req = 1'b1; clk_valid = 1'b0; end
    @(negedge clk) rst_req = 1'b0;
    chk(lol, 1'b1, "R1 rst_req raises lol");
    wait_n(300);
    chk(lol, 1'b1, "R1 rst_req waiting for clk_valid");
    clk_valid = 1'b1;
    @(negedge clk);
    check_fall(exp_limit(7) + 1, "R1 release after rst_req");

    // Long idle beyond the timer's full count.
    set_code(0);
    bad_seen = 1'b0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (lol !== 1'b0) bad_seen = 1'b1;
    end
    chk(bad_seen, 1'b0, "R8 timer saturation, no spurious lol");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule